// File: doc/BRIEF.md
# Shared Cache Maintenance Controller

This block sequences maintenance operations on a small direct-mapped cache shared by two hardware threads. Each thread can request one of three operations: discard every line, write back every dirty line and then discard every line, or write back and discard the single line that holds a given address. The tag, valid, dirty and data state of the cache lives inside the block as registers. A minimal lookup port reads and fills that state so that lines can be created, and it stands in for normal cache traffic.

Requests are taken one at a time. Thread 0 wins when both threads ask in the same cycle. While either whole-cache operation runs, both threads see their stall outputs raised. Dirty data leaves through a request/acknowledge memory write port. The finish of every operation is marked by a one-cycle notification to the other caching agents and by a one-cycle completion pulse to the requesting thread. Each thread also drives its own cache-disable bit, and setting either bit turns off hits and allocation for everyone.

Top module: `cache_maint_ctrl`

## Requirements
- R1: Op code 1 (discard all) clears the valid bit of every line and issues no memory write request at any time during the operation, even for dirty lines.
- R2: For op codes 1 and 2, stall_o is 2'b11 from the cycle after acceptance through the cycle in which done is high, and it is never unequal across threads. For op code 3, stall_o stays 2'b00.
- R3: Op code 2 (write back and discard all) issues one memory write per valid dirty line, in ascending line index order. Each write carries address {tag, index} and the line data. Every line is invalid afterwards. The operation takes LINES + (number of dirty lines) + 1 cycles from the request cycle to the done cycle, given a one-cycle acknowledge.
- R4: Op code 3 (flush line) on a resident line writes it back first if it is dirty, then invalidates only that line. Other lines keep their contents. On a non-resident line it writes nothing and still completes.
- R5: A flush acts on a resident line whichever thread issued the flush and whichever thread's traffic filled the line.
- R6: At completion, bcast_o pulses for one cycle in the same cycle as done. bcast_line_o is 1 and bcast_addr_o equals the flush address for op 3. bcast_line_o is 0 for ops 1 and 2.
- R7: The effective disable is the OR of the per-thread bits in cache_dis_i. While it is set, every lookup misses and no line is allocated or modified.
- R8: Requests are served one at a time, with thread 0 first when both are pending. The done_o vector has at most one bit set at a time.
- R9: done_o[t] for the requesting thread t is high for exactly one cycle, in the cycle after the final invalidate or write-back step.
- R10: mem_req_o, once raised, stays high with mem_addr_o and mem_data_o unchanged until the cycle in which mem_ack_i is sampled high.
- R11: Lookup stub behaviour. The address index is lk_addr_i[IDX_W-1:0] and the tag is the upper bits. A hit requires a valid line with a matching tag. A write miss allocates a dirty line holding lk_wdata_i. A read miss allocates a clean line holding zero. A lookup made while an operation is in progress misses and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | N_THR | Per-thread request, held until that thread's done pulse |
| cmd_op_i | input | 2*N_THR | Per-thread op code: 1 discard all, 2 write back and discard all, 3 flush line, 0 none |
| cmd_addr_i | input | ADDR_W*N_THR | Per-thread flush address |
| cache_dis_i | input | N_THR | Per-thread cache-disable bits |
| stall_o | output | N_THR | Stall to each thread during whole-cache operations |
| done_o | output | N_THR | Completion pulse to the requesting thread |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_write_i | input | 1 | Lookup is a write |
| lk_addr_i | input | ADDR_W | Lookup address |
| lk_wdata_i | input | DATA_W | Lookup write data |
| lk_hit_o | output | 1 | Lookup hit |
| lk_rdata_o | output | DATA_W | Line data on hit, zero otherwise |
| mem_req_o | output | 1 | Write-back request |
| mem_addr_o | output | ADDR_W | Write-back address |
| mem_data_o | output | DATA_W | Write-back data |
| mem_ack_i | input | 1 | Write-back acknowledge |
| bcast_o | output | 1 | Notification pulse to other caching agents |
| bcast_line_o | output | 1 | Notification concerns a single line |
| bcast_addr_o | output | ADDR_W | Line address of a single-line notification |

## Verification
The assertions assume that a thread keeps its request, op code and address steady from the moment it raises the request until it sees its done pulse. They also assume that mem_ack_i is raised only while a write-back request is pending and is never held for two consecutive cycles. The bench drives requests on falling edges and releases each one in the cycle its done pulse appears. Its memory model acknowledges a pending request one cycle after seeing it and then drops the acknowledge, which keeps every stimulus inside those assumptions.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    OP_NONE       = 2'd0,
    OP_INV_ALL    = 2'd1,
    OP_WB_INV_ALL = 2'd2,
    OP_FLUSH_LINE = 2'd3
  } cmc_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WALK,
    S_LINE,
    S_WB,
    S_DONE
  } cmc_state_e;
endpackage

// File: rtl/cmc_arb.sv
module cmc_arb #(
  parameter int N_THR = 2,
  localparam int ID_W = (N_THR > 1) ? $clog2(N_THR) : 1
) (
  input  logic [N_THR-1:0] req_i,
  output logic             any_o,
  output logic [ID_W-1:0]  gnt_id_o
);
  // lowest index wins
  always_comb begin
    gnt_id_o = '0;
    for (int i = N_THR - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_id_o = ID_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/cmc_tag_store.sv
module cmc_tag_store #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_allow_i,
  input  logic              lk_valid_i,
  input  logic              lk_write_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [DATA_W-1:0] lk_wdata_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_rdata_o,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic              rd_dirty_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              clr_en_i
);
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_en;

  assign lk_idx     = lk_addr_i[IDX_W-1:0];
  assign lk_tag     = lk_addr_i[ADDR_W-1:IDX_W];
  assign lk_en      = lk_valid_i && lk_allow_i;
  assign lk_hit_o   = lk_en && valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_rdata_o = lk_hit_o ? data_q[lk_idx] : '0;

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_dirty_o = dirty_q[rd_idx_i];
  assign rd_tag_o   = tag_q[rd_idx_i];
  assign rd_data_o  = data_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (clr_en_i) begin
      valid_q[rd_idx_i] <= 1'b0;
      dirty_q[rd_idx_i] <= 1'b0;
    end else if (lk_en) begin
      if (lk_hit_o) begin
        if (lk_write_i) begin
          data_q[lk_idx]  <= lk_wdata_i;
          dirty_q[lk_idx] <= 1'b1;
        end
      end else begin
        valid_q[lk_idx] <= 1'b1;
        tag_q[lk_idx]   <= lk_tag;
        dirty_q[lk_idx] <= lk_write_i;
        data_q[lk_idx]  <= lk_write_i ? lk_wdata_i : '0;
      end
    end
  end
endmodule

// File: rtl/cmc_seq.sv
module cmc_seq
  import cmc_pkg::*;
#(
  parameter int N_THR  = 2,
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  localparam int ID_W  = (N_THR > 1) ? $clog2(N_THR) : 1,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   start_id_i,
  input  cmc_op_e           start_op_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  output logic              idle_o,
  output cmc_op_e           op_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic              rd_dirty_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              clr_en_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  output logic              stall_all_o,
  output logic [N_THR-1:0]  done_o,
  output logic              bcast_o,
  output logic              bcast_line_o,
  output logic [ADDR_W-1:0] bcast_addr_o
);
  cmc_state_e        state_q, state_d;
  cmc_op_e           op_q;
  logic [ID_W-1:0]   id_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [ADDR_W-1:0] addr_q;
  logic              last, line_match;

  assign last       = (idx_q == IDX_W'(LINES - 1));
  assign line_match = rd_valid_i && (rd_tag_i == addr_q[ADDR_W-1:IDX_W]);

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    clr_en_o = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = (start_op_i == OP_FLUSH_LINE) ? S_LINE : S_WALK;
          idx_d   = (start_op_i == OP_FLUSH_LINE) ? start_addr_i[IDX_W-1:0] : '0;
        end
      end
      S_WALK: begin
        if (op_q == OP_WB_INV_ALL && rd_valid_i && rd_dirty_i) begin
          state_d = S_WB;
        end else begin
          clr_en_o = 1'b1;
          if (last) state_d = S_DONE;
          else idx_d = idx_q + 1'b1;
        end
      end
      S_LINE: begin
        if (line_match && rd_dirty_i) begin
          state_d = S_WB;
        end else begin
          clr_en_o = line_match;
          state_d  = S_DONE;
        end
      end
      S_WB: begin
        if (mem_ack_i) begin
          clr_en_o = 1'b1;
          if (op_q == OP_FLUSH_LINE || last) begin
            state_d = S_DONE;
          end else begin
            state_d = S_WALK;
            idx_d   = idx_q + 1'b1;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_NONE;
      id_q    <= '0;
      idx_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (state_q == S_IDLE && start_i) begin
        op_q   <= start_op_i;
        id_q   <= start_id_i;
        addr_q <= start_addr_i;
      end
    end
  end

  always_comb begin
    done_o = '0;
    if (state_q == S_DONE) done_o[id_q] = 1'b1;
  end

  assign idle_o       = (state_q == S_IDLE);
  assign op_o         = op_q;
  assign rd_idx_o     = idx_q;
  assign mem_req_o    = (state_q == S_WB);
  assign mem_addr_o   = {rd_tag_i, idx_q};
  assign stall_all_o  = !idle_o && (op_q != OP_FLUSH_LINE);
  assign bcast_o      = (state_q == S_DONE);
  assign bcast_line_o = bcast_o && (op_q == OP_FLUSH_LINE);
  assign bcast_addr_o = bcast_line_o ? addr_q : '0;
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
  import cmc_pkg::*;
#(
  parameter int N_THR  = 2,
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_THR-1:0]        cmd_valid_i,
  input  logic [2*N_THR-1:0]      cmd_op_i,
  input  logic [ADDR_W*N_THR-1:0] cmd_addr_i,
  input  logic [N_THR-1:0]        cache_dis_i,
  output logic [N_THR-1:0]        stall_o,
  output logic [N_THR-1:0]        done_o,
  input  logic                    lk_valid_i,
  input  logic                    lk_write_i,
  input  logic [ADDR_W-1:0]       lk_addr_i,
  input  logic [DATA_W-1:0]       lk_wdata_i,
  output logic                    lk_hit_o,
  output logic [DATA_W-1:0]       lk_rdata_o,
  output logic                    mem_req_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [DATA_W-1:0]       mem_data_o,
  input  logic                    mem_ack_i,
  output logic                    bcast_o,
  output logic                    bcast_line_o,
  output logic [ADDR_W-1:0]       bcast_addr_o
);
  localparam int ID_W  = (N_THR > 1) ? $clog2(N_THR) : 1;
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [N_THR-1:0] req;
  logic             req_any, idle, clr_en, stall_all, rd_valid, rd_dirty;
  logic [ID_W-1:0]  gnt_id;
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  cmc_op_e          cur_op;

  for (genvar t = 0; t < N_THR; t++) begin : g_req
    assign req[t]     = cmd_valid_i[t] && (cmd_op_i[2*t +: 2] != OP_NONE);
    assign stall_o[t] = stall_all;
  end

  cmc_arb #(.N_THR(N_THR)) u_arb (
    .req_i   (req),
    .any_o   (req_any),
    .gnt_id_o(gnt_id)
  );

  cmc_seq #(.N_THR(N_THR), .LINES(LINES), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (req_any),
    .start_id_i  (gnt_id),
    .start_op_i  (cmc_op_e'(cmd_op_i[2*gnt_id +: 2])),
    .start_addr_i(cmd_addr_i[ADDR_W*gnt_id +: ADDR_W]),
    .idle_o      (idle),
    .op_o        (cur_op),
    .rd_idx_o    (rd_idx),
    .rd_valid_i  (rd_valid),
    .rd_dirty_i  (rd_dirty),
    .rd_tag_i    (rd_tag),
    .clr_en_o    (clr_en),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .stall_all_o (stall_all),
    .done_o      (done_o),
    .bcast_o     (bcast_o),
    .bcast_line_o(bcast_line_o),
    .bcast_addr_o(bcast_addr_o)
  );

  cmc_tag_store #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lk_allow_i(idle && !(|cache_dis_i)),
    .lk_valid_i(lk_valid_i),
    .lk_write_i(lk_write_i),
    .lk_addr_i (lk_addr_i),
    .lk_wdata_i(lk_wdata_i),
    .lk_hit_o  (lk_hit_o),
    .lk_rdata_o(lk_rdata_o),
    .rd_idx_i  (rd_idx),
    .rd_valid_o(rd_valid),
    .rd_dirty_o(rd_dirty),
    .rd_tag_o  (rd_tag),
    .rd_data_o (mem_data_o),
    .clr_en_i  (clr_en)
  );
endmodule

// File: rtl/cache_maint_ctrl_chk.sv
module cache_maint_ctrl_chk
  import cmc_pkg::*;
#(
  parameter int N_THR  = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_THR-1:0]  stall_o,
  input logic [N_THR-1:0]  done_o,
  input logic [N_THR-1:0]  cache_dis_i,
  input logic              lk_hit_o,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              bcast_o,
  input cmc_op_e           cur_op
);
  AST_INV_NO_WRITEBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o[0] && cur_op == OP_INV_ALL) |-> !mem_req_o); // R1
  AST_STALL_SHARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o == '0) || (stall_o == '1)); // R2
  AST_BCAST_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> (|done_o)); // R6
  AST_DISABLE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cache_dis_i) |-> !lk_hit_o); // R7
  AST_DONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |=> (done_o == '0)); // R9
  AST_MEM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R10
  AST_BUSY_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || stall_o[0]) |-> !lk_hit_o); // R11
endmodule

bind cache_maint_ctrl cache_maint_ctrl_chk #(
  .N_THR(N_THR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_o    (stall_o),
  .done_o     (done_o),
  .cache_dis_i(cache_dis_i),
  .lk_hit_o   (lk_hit_o),
  .mem_req_o  (mem_req_o),
  .mem_ack_i  (mem_ack_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .bcast_o    (bcast_o),
  .cur_op     (cur_op)
);

// File: tb/tb_cache_maint_ctrl.sv
module tb_cache_maint_ctrl;
  localparam int N_THR = 2, LINES = 8, ADDR_W = 8, DATA_W = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N_THR-1:0] cmd_valid_i = '0, cache_dis_i = '0;
  logic [2*N_THR-1:0] cmd_op_i = '0;
  logic [ADDR_W*N_THR-1:0] cmd_addr_i = '0;
  logic [N_THR-1:0] stall_o, done_o;
  logic lk_valid_i = 1'b0, lk_write_i = 1'b0, lk_hit_o;
  logic [ADDR_W-1:0] lk_addr_i = '0, mem_addr_o, bcast_addr_o;
  logic [DATA_W-1:0] lk_wdata_i = '0, lk_rdata_o, mem_data_o;
  logic mem_req_o, mem_ack_i = 1'b0, bcast_o, bcast_line_o;

  always #2.5 clk_i = ~clk_i;

  cache_maint_ctrl #(.N_THR(N_THR), .LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model of the line state
  bit       m_valid [LINES];
  bit       m_dirty [LINES];
  bit [4:0] m_tag   [LINES];
  bit [7:0] m_data  [LINES];

  // write-back log
  bit [7:0] wb_addr [64];
  bit [7:0] wb_data [64];
  int wb_n = 0;

  always @(negedge clk_i) begin
    if (mem_ack_i) mem_ack_i <= 1'b0;
    else if (mem_req_o && rst_ni) begin
      if (wb_n < 64) begin
        wb_addr[wb_n] <= mem_addr_o;
        wb_data[wb_n] <= mem_data_o;
      end
      wb_n <= wb_n + 1;
      mem_ack_i <= 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(bit [7:0] a, bit wr, bit [7:0] d, string req);
    int i = int'(a[2:0]);
    bit dis = |cache_dis_i;
    bit exp_hit = !dis && m_valid[i] && (m_tag[i] == a[7:3]);
    lk_valid_i = 1'b1; lk_write_i = wr; lk_addr_i = a; lk_wdata_i = d;
    #1;
    chk({req, " hit"}, int'(lk_hit_o), int'(exp_hit));
    if (exp_hit) chk({req, " rdata"}, int'(lk_rdata_o), int'(m_data[i]));
    if (!dis) begin
      if (exp_hit) begin
        if (wr) begin m_data[i] = d; m_dirty[i] = 1'b1; end
      end else begin
        m_valid[i] = 1'b1; m_tag[i] = a[7:3]; m_dirty[i] = wr; m_data[i] = wr ? d : 8'h00;
      end
    end
    @(negedge clk_i);
    lk_valid_i = 1'b0; lk_write_i = 1'b0;
  endtask

  // issue one operation and check every observable effect
  task automatic run_cmd(int tid, bit [1:0] op, bit [7:0] a);
    bit [7:0] ea [LINES];
    bit [7:0] ed [LINES];
    int ne = 0, base, cyc = 0, stall_bad = 0, exp_cyc;
    bit whole = (op != 2'd3);
    if (op == 2'd2) begin
      for (int i = 0; i < LINES; i++)
        if (m_valid[i] && m_dirty[i]) begin ea[ne] = {m_tag[i], 3'(i)}; ed[ne] = m_data[i]; ne++; end
    end else if (op == 2'd3) begin
      int i = int'(a[2:0]);
      if (m_valid[i] && m_dirty[i] && m_tag[i] == a[7:3]) begin ea[0] = a; ed[0] = m_data[i]; ne = 1; end
    end
    if (op == 2'd3) exp_cyc = (m_valid[a[2:0]] && m_tag[a[2:0]] == a[7:3] && m_dirty[a[2:0]]) ? 3 : 2;
    else exp_cyc = LINES + ne + 1;
    base = wb_n;
    cmd_valid_i[tid] = 1'b1; cmd_op_i[2*tid +: 2] = op; cmd_addr_i[8*tid +: 8] = a;
    do begin
      @(negedge clk_i);
      cyc++;
      if (stall_o != (whole ? 2'b11 : 2'b00)) stall_bad++;
    end while (!done_o[tid] && cyc < 2000);
    chk("R2 stall level", stall_bad, 0);
    chk("R3/R9 cycles to done", cyc, exp_cyc);
    chk("R8 done vector", int'(done_o), 1 << tid);
    chk("R6 bcast", int'(bcast_o), 1);
    chk("R6 bcast line", int'(bcast_line_o), int'(op == 2'd3));
    if (op == 2'd3) chk("R6 bcast addr", int'(bcast_addr_o), int'(a));
    cmd_valid_i[tid] = 1'b0;
    @(negedge clk_i);
    chk("R9 done single cycle", int'(done_o), 0);
    chk("R1/R3/R4 write-back count", wb_n - base, ne);
    for (int k = 0; k < ne && (base + k) < 64; k++) begin
      chk("R3/R4 wb addr", int'(wb_addr[base + k]), int'(ea[k]));
      chk("R3/R4 wb data", int'(wb_data[base + k]), int'(ed[k]));
    end
    if (op == 2'd3) begin
      int i = int'(a[2:0]);
      if (m_valid[i] && m_tag[i] == a[7:3]) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    end else begin
      for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    end
  endtask

  task automatic t_reset;
    chk("R2 reset stall", int'(stall_o), 0);
    chk("R9 reset done", int'(done_o), 0);
    chk("R10 reset mem_req", int'(mem_req_o), 0);
    chk("R6 reset bcast", int'(bcast_o), 0);
    lookup(8'h13, 1'b0, 8'h00, "R11 reset miss");
  endtask

  task automatic t_fill;
    lookup(8'h10, 1'b1, 8'hA1, "R11 write miss");
    lookup(8'h10, 1'b0, 8'h00, "R11 read hit");
    lookup(8'h25, 1'b0, 8'h00, "R11 read miss");
    lookup(8'h25, 1'b0, 8'h00, "R11 clean hit");
    lookup(8'h3F, 1'b1, 8'h5C, "R11 write miss");
    lookup(8'h12, 1'b1, 8'h77, "R11 write miss");
  endtask

  task automatic t_inv_all;
    run_cmd(0, 2'd1, 8'h00);
    lookup(8'h10, 1'b0, 8'h00, "R1 dirty line gone");
    lookup(8'h3F, 1'b0, 8'h00, "R1 line gone");
  endtask

  task automatic t_wbinv;
    t_fill();
    run_cmd(1, 2'd2, 8'h00);
    lookup(8'h12, 1'b0, 8'h00, "R3 line gone");
  endtask

  task automatic t_flush;
    lookup(8'h44, 1'b1, 8'h3C, "R11 fill by traffic");
    lookup(8'h45, 1'b1, 8'h9D, "R11 fill");
    run_cmd(1, 2'd3, 8'h44);
    lookup(8'h44, 1'b0, 8'h00, "R4/R5 flushed line misses");
    lookup(8'h45, 1'b0, 8'h00, "R4 neighbour kept");
    run_cmd(0, 2'd3, 8'hE5);
    lookup(8'h45, 1'b0, 8'h00, "R4 tag mismatch keeps line");
    run_cmd(0, 2'd3, 8'h45);
  endtask

  task automatic t_disable;
    lookup(8'h31, 1'b1, 8'h11, "R11 fill");
    cache_dis_i = 2'b10;
    lookup(8'h31, 1'b1, 8'hEE, "R7 disabled thread1 miss");
    cache_dis_i = 2'b01;
    lookup(8'h52, 1'b1, 8'hEE, "R7 disabled thread0 no alloc");
    cache_dis_i = 2'b00;
    lookup(8'h31, 1'b0, 8'h00, "R7 line unchanged");
    lookup(8'h52, 1'b0, 8'h00, "R7 not allocated");
  endtask

  task automatic t_arb;
    int cyc = 0;
    bit t1_early = 1'b0;
    cmd_valid_i = 2'b11; cmd_op_i = {2'd3, 2'd1}; cmd_addr_i = {8'h31, 8'h00};
    do begin
      @(negedge clk_i);
      cyc++;
      if (done_o[1]) t1_early = 1'b1;
    end while (!done_o[0] && cyc < 2000);
    chk("R8 thread0 first", int'(done_o), 1);
    chk("R8 thread1 waits", int'(t1_early), 0);
    cmd_valid_i[0] = 1'b0;
    for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    cyc = 0;
    do begin @(negedge clk_i); cyc++; end while (!done_o[1] && cyc < 2000);
    chk("R8 thread1 served", int'(done_o), 2);
    chk("R6 flush notify", int'(bcast_line_o), 1);
    cmd_valid_i[1] = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_busy_lookup;
    int cyc = 0;
    lookup(8'h1B, 1'b1, 8'h42, "R11 fill");
    cmd_valid_i[0] = 1'b1; cmd_op_i[1:0] = 2'd1;
    @(negedge clk_i);
    lk_valid_i = 1'b1; lk_write_i = 1'b1; lk_addr_i = 8'h66; lk_wdata_i = 8'h99;
    #1;
    chk("R11 busy lookup misses", int'(lk_hit_o), 0);
    do begin @(negedge clk_i); cyc++; end while (!done_o[0] && cyc < 2000);
    lk_valid_i = 1'b0; lk_write_i = 1'b0;
    cmd_valid_i[0] = 1'b0;
    for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    @(negedge clk_i);
    lookup(8'h66, 1'b0, 8'h00, "R11 no alloc while busy");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fill();
    t_inv_all();
    t_wbinv();
    t_flush();
    t_disable();
    t_arb();
    t_busy_lookup();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule